// File: doc/BRIEF.md
# Timer Interrupt Pending and Acknowledge Tracker

This block sits between a periodic timer tick and one interrupt controller input. Each tick adds one to a pending count. The block then delivers those ticks as single-cycle interrupt pulses, one at a time. After each pulse it holds off until the controller acknowledges. An acknowledge retires one pending tick, so ticks that piled up while the system was slow are replayed one per acknowledge. When the reinject setting is off, a tick collapses the backlog to exactly one pending tick, so missed ticks are dropped instead of replayed.

Two events discard the backlog and leave the line acknowledged: a reload of the timer and an unmask of the interrupt line. The pending count is exported for observation.

The delivery side is a three-state machine:
- IDLE: the last pulse has been acknowledged.
- FIRE: the one-cycle pulse is on the line.
- WAIT: a pulse was delivered and no acknowledge has come yet.

Its transitions are:
- IDLE to FIRE when the count is nonzero.
- FIRE to IDLE on an acknowledge, otherwise FIRE to WAIT.
- WAIT to IDLE on an acknowledge.
- Any state to IDLE on a clear (reload or unmask).

Top module: `timer_irq_tracker`

## Requirements
- R1: After reset the pending count is 0, `irq_o` is low, and the tracker is in the acknowledged state (IDLE).
- R2: With reinject enabled, a tick alone raises the pending count by one on the next clock edge.
- R3: With reinject disabled, a tick sets the pending count to exactly 1 on the next clock edge. This holds whatever the previous count was and whether or not an acknowledge arrives in the same cycle.
- R4: A pulse starts only from IDLE with a nonzero count. While in WAIT without an acknowledge, `irq_o` stays low however many ticks arrive.
- R5: An acknowledge alone lowers a nonzero count by one, leaves a zero count at zero, and returns the machine to IDLE. If the count is still nonzero, a new pulse follows.
- R6: A reload or an unmask clears the count to 0 and returns the machine to IDLE on the next edge. The clear takes priority over a tick or an acknowledge in the same cycle, and no pulse follows in the cycle after it.
- R7: Each delivery is `irq_o` high for exactly one cycle. The pulse appears in the cycle after an edge at which the machine was IDLE and the count was nonzero.
- R8: With reinject enabled, the count saturates at 2^CNT_W-1 (15 by default) instead of wrapping.
- R9: With reinject enabled, a tick and an acknowledge in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timer expiry strobe |
| ack_i | input | 1 | One-cycle interrupt acknowledge from the controller |
| unmask_i | input | 1 | One-cycle strobe: interrupt line was unmasked |
| reload_i | input | 1 | One-cycle strobe: timer was reprogrammed |
| reinject_en_i | input | 1 | 1 replays missed ticks, 0 collapses them to one |
| irq_o | output | 1 | Interrupt pulse to the controller |
| pend_cnt_o | output | CNT_W | Current pending tick count |

## Verification
The assertions check the following on every cycle:
- the one-cycle pulse shape;
- that no pulse appears while waiting for an acknowledge;
- that a clear empties the count and suppresses the next pulse;
- saturation at the top value, the floor at zero, the collapse to one, and the net-zero effect of a simultaneous tick and acknowledge.

Only the bench scenarios can show the end-to-end sequences:
- a burst of ticks replayed one pulse per acknowledge in the right cycles;
- a backlog discarded by unmask or reload part way through a replay;
- the change in behaviour when the reinject setting is switched off mid-run.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_WAIT = 2'd2
    } tirq_state_e;

endpackage

// File: rtl/tirq_pending_counter.sv
module tirq_pending_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic             ack_i,
    input  logic             reinject_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_dec;

    // Saturating step values
    always_comb begin
        cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
        cnt_dec = (cnt_q == '0) ? '0 : cnt_q - CNT_ONE;
    end

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i && !reinject_i) begin
            cnt_d = CNT_ONE;
        end else begin
            unique case ({tick_i, ack_i})
                2'b10:   cnt_d = cnt_inc;
                2'b01:   cnt_d = cnt_dec;
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && tick_i && !ack_i && reinject_i && !clear_i) |=> (cnt_q == CNT_MAX)); // R8
    AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && ack_i && !tick_i && !clear_i) |=> (cnt_q == '0)); // R5
    AST_CNT_COLLAPSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !reinject_i && !clear_i) |=> (cnt_q == CNT_ONE)); // R3
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0)); // R6
    AST_CNT_TICK_ACK_NET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ack_i && reinject_i && !clear_i) |=> $stable(cnt_q)); // R9
    AST_CNT_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_MAX && tick_i && !ack_i && reinject_i && !clear_i)
        |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R2

endmodule

// File: rtl/tirq_delivery_fsm.sv
module tirq_delivery_fsm
    import tirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic ack_i,
    input  logic pend_nz_i,
    output logic irq_o
);
    tirq_state_e state_q;
    tirq_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (pend_nz_i) state_d = ST_FIRE;
                ST_FIRE: state_d = ack_i ? ST_IDLE : ST_WAIT;
                ST_WAIT: if (ack_i) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        irq_o = (state_q == ST_FIRE);
    end

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R7
    AST_IRQ_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pend_nz_i && !clear_i) |=> irq_o); // R7
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !pend_nz_i) |=> !irq_o); // R4
    AST_IRQ_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !ack_i) |=> !irq_o); // R4
    AST_IRQ_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!irq_o && state_q == ST_IDLE)); // R6

endmodule

// File: rtl/timer_irq_tracker.sv
module timer_irq_tracker #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ack_i,
    input  logic             unmask_i,
    input  logic             reload_i,
    input  logic             reinject_en_i,
    output logic             irq_o,
    output logic [CNT_W-1:0] pend_cnt_o
);
    logic             clear_w;
    logic [CNT_W-1:0] cnt_w;

    assign clear_w = unmask_i | reload_i;

    tirq_pending_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_w),
        .tick_i     (tick_i),
        .ack_i      (ack_i),
        .reinject_i (reinject_en_i),
        .cnt_o      (cnt_w)
    );

    tirq_delivery_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_w),
        .ack_i     (ack_i),
        .pend_nz_i (cnt_w != '0),
        .irq_o     (irq_o)
    );

    assign pend_cnt_o = cnt_w;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && pend_cnt_o == '0)); // R1

endmodule

// File: tb/timer_irq_tracker_test.sv
module timer_irq_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int MAXV       = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0, ack_i = 1'b0, unmask_i = 1'b0, reload_i = 1'b0;
    logic reinject_en_i = 1'b1;
    logic irq_o;
    logic [CNT_W-1:0] pend_cnt_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench-side model state: count and delivery phase (0 idle, 1 fire, 2 wait)
    int m_cnt = 0;
    int m_ph  = 0;

    logic  exp_irq_q[$];
    int    exp_cnt_q[$];
    string tag_q[$];

    timer_irq_tracker #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ack_i(ack_i),
        .unmask_i(unmask_i), .reload_i(reload_i), .reinject_en_i(reinject_en_i),
        .irq_o(irq_o), .pend_cnt_o(pend_cnt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic act_irq, input int act_cnt,
                         input logic e_irq, input int e_cnt);
        checks++;
        if (act_irq !== e_irq || act_cnt != e_cnt) begin
            errors++;
            $display("FAIL %s: irq=%0b cnt=%0d expected irq=%0b cnt=%0d",
                     tag, act_irq, act_cnt, e_irq, e_cnt);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected post-edge result
    task automatic step(input logic t, input logic a, input logic u, input logic r,
                        input string tag);
        int n_cnt;
        int n_ph;
        @(negedge clk);
        tick_i = t; ack_i = a; unmask_i = u; reload_i = r;
        n_cnt = m_cnt;
        n_ph  = m_ph;
        if (u || r) begin
            n_cnt = 0;
            n_ph  = 0;
        end else begin
            if (t && !reinject_en_i)  n_cnt = 1;
            else if (t && a)          n_cnt = m_cnt;
            else if (t)               n_cnt = (m_cnt == MAXV) ? MAXV : m_cnt + 1;
            else if (a)               n_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
            if (m_ph == 0)      n_ph = (m_cnt != 0) ? 1 : 0;
            else if (m_ph == 1) n_ph = a ? 0 : 2;
            else                n_ph = a ? 0 : 2;
        end
        m_cnt = n_cnt;
        m_ph  = n_ph;
        exp_irq_q.push_back(n_ph == 1);
        exp_cnt_q.push_back(n_cnt);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare a quarter period after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_irq_q.size() > 0) begin
                check(tag_q.pop_front(), irq_o, int'(pend_cnt_o),
                      exp_irq_q.pop_front(), exp_cnt_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: irq=%0b cnt=%0d expected run completion", irq_o, pend_cnt_o);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", irq_o, int'(pend_cnt_o), 1'b0, 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, "R1 idle after reset");
        step(0, 0, 0, 0, "R1 idle after reset");

        // R2 / R7 / R4: three ticks, one pulse, then hold-off
        step(1, 0, 0, 0, "R2 tick one");
        step(1, 0, 0, 0, "R2 tick two R7 pulse");
        step(1, 0, 0, 0, "R2 tick three R7 pulse ends");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R4 no pulse while waiting");
        step(1, 0, 0, 0, "R4 tick while waiting");

        // R5: replay one per acknowledge
        for (int i = 0; i < 4; i++) begin
            step(0, 1, 0, 0, "R5 ack retires one");
            step(0, 0, 0, 0, "R5 R7 replay pulse");
            step(0, 0, 0, 0, "R5 wait after replay");
        end
        step(0, 1, 0, 0, "R5 ack at zero floors");
        step(0, 1, 0, 0, "R5 ack at zero floors");
        step(0, 0, 0, 0, "R5 no pulse at zero");

        // R8: saturation
        for (int i = 0; i < MAXV + 3; i++) step(1, 0, 0, 0, "R8 saturate");
        // R9: tick and ack together
        step(1, 1, 0, 0, "R9 tick with ack");
        step(1, 1, 0, 0, "R9 tick with ack");
        step(0, 0, 0, 0, "R9 settle");
        // R6: unmask clears mid replay, priority over tick
        step(1, 0, 1, 0, "R6 unmask clears");
        step(0, 0, 0, 0, "R6 no pulse after unmask");
        step(1, 0, 0, 0, "R6 tick after unmask");
        step(1, 0, 0, 0, "R6 R7 pulse after unmask");
        step(1, 1, 0, 1, "R6 reload clears");
        step(0, 0, 0, 0, "R6 quiet after reload");

        // R3: collapse mode
        reinject_en_i = 1'b0;
        step(1, 0, 0, 0, "R3 collapse tick");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R3 collapse repeated");
        step(1, 1, 0, 0, "R3 collapse with ack");
        step(0, 1, 0, 0, "R3 ack drains");
        step(0, 0, 0, 0, "R3 drained");
        reinject_en_i = 1'b1;
        step(1, 0, 0, 0, "R2 back to replay");
        step(1, 0, 0, 0, "R2 back to replay");
        step(0, 0, 0, 0, "R2 settle");
        step(0, 0, 0, 0, "R2 settle");

        @(negedge clk);
        tick_i = 0; ack_i = 0; unmask_i = 0; reload_i = 0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule